// File: doc/BRIEF.md
# I2C Slave Write Receiver with General-Call Recognition

This block is the slave-receive half of an I2C port. It runs on the system clock. SCL and SDA are oversampled through a synchroniser and a short agreement filter. START, repeated START and STOP are detected on the filtered lines. The first byte after a START is decoded as an address. It is accepted when it carries the write bit and either equals the programmed own address, or is the all-zero general-call address while the general-call enable is set.

Every accepted address, every received data byte and every bus stop or restart that arrives while the port is addressed produces an 8-bit status code and raises the SI flag. For byte events the port also holds SCL low until software answers. Software answers with a single control write that carries four bits:

- SI=1 clears the flag and releases SCL.
- AA is the acknowledge policy for the next byte.
- STA asks for a START once the bus is free. That request leaves the block as a one-cycle pulse on `start_go_o`, for the master side.
- STO drops the receiver back to not-addressed.

A lost-arbitration pulse from the master side changes the next address status to its arbitration variant.

Received bytes leave through `rx_data_o` under the SI handshake. The byte is valid while SI is set with a data status, and the control write that clears SI is the consumer's "ready". No new byte can arrive before that write, because SCL stays held.

Top module: `i2cgc_slave_rx`

## Requirements
- R1: After reset, `status_o` reads 0xF8, `si_o` is 0, neither line is pulled low and the address register holds 0x00. The own-address half of the register (bits 7:1) only matches when it is nonzero.
- R2: The address register's bit 0 is the general-call enable.
  - With bit 0 = 1 and AA = 1, the address byte 0x00 is acknowledged: SDA is low during the ninth clock and the status is 0x70.
  - With bit 0 = 0, the byte 0x00 gets no acknowledge and SI stays 0.
- R3: An address byte whose upper seven bits equal a nonzero register bits 7:1, and whose bit 0 is 0, is acknowledged with status 0x60.
- R4: After a pulse on `arb_lost_i`, the next accepted address reports the arbitration variant: 0x78 for a general call, 0x68 for the own address.
- R5: A data byte is shifted in MSB first and shown on `rx_data_o` with the status. The acknowledge comes from AA as it stood when the eighth SCL clock ended.
  - In general-call mode the status is 0x90 when acknowledged and 0x98 when not.
  - In own-address mode the status is 0x80 when acknowledged and 0x88 when not.
- R6: A STOP or a repeated START while addressed reports 0xA0 and does not hold SCL. After a repeated START the next byte is decoded as an address.
- R7: After a not-acknowledged data byte, or after 0xA0, the port is not addressed. Further bytes before the next START raise no SI. While AA = 0, both the own address and the general call get no acknowledge.
- R8: A control write with STA = 1 yields exactly one `start_go_o` pulse. The pulse comes only once the bus is free, that is, after a STOP.
- R9: Each accepted address gives one single-cycle `wake_o` pulse, while the acknowledge is being driven. Rejected addresses give none.
- R10: SI is set for every status. While SI = 0, `status_o` reads 0xF8. SCL is held low while SI is set after a byte event. A control write with SI = 1 clears SI and releases SCL on the next cycle.
- R11: A pulse on SDA or SCL shorter than the filter length is ignored. For example, a one-cycle SDA high pulse while SCL is high and SDA is low creates no STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low (clock hold) |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge) |
| addr_we_i | input | 1 | Write strobe for the address register |
| addr_wdata_i | input | 8 | Bits 7:1 own address, bit 0 general-call enable |
| ctl_we_i | input | 1 | Control write strobe |
| ctl_sta_i | input | 1 | Request a START when the bus is free |
| ctl_sto_i | input | 1 | Force not-addressed, release SDA |
| ctl_si_i | input | 1 | 1 clears SI and releases SCL |
| ctl_aa_i | input | 1 | Acknowledge policy for following bytes |
| arb_lost_i | input | 1 | Pulse: the master side lost arbitration |
| status_o | output | 8 | Status code, 0xF8 while SI is 0 |
| si_o | output | 1 | Interrupt flag |
| rx_data_o | output | 8 | Last received data byte |
| wake_o | output | 1 | One-cycle pulse on an address match |
| start_go_o | output | 1 | One-cycle pulse: issue the queued START |

## Verification
The assertions take for granted that software does not rewrite the address register while SI is set. They also assume every status is answered before the master completes another byte. A well-formed master never sends a new byte without first releasing SCL, so that second assumption holds for it.

The stimulus keeps within these assumptions. The driver touches the address register only between transfers. The single software process clears SI for each status before the held ninth clock can end. Bus edges are separated by many clock cycles, so only the deliberate glitch is shorter than the filter.

// File: rtl/i2cgc_pkg.sv
package i2cgc_pkg;
  localparam int BYTE_BITS = 8;
  localparam int CNT_W     = $clog2(BYTE_BITS + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA, ST_ACK} eng_state_t;

  localparam logic [7:0] SC_OWN_ACK  = 8'h60;
  localparam logic [7:0] SC_OWN_ARB  = 8'h68;
  localparam logic [7:0] SC_GC_ACK   = 8'h70;
  localparam logic [7:0] SC_GC_ARB   = 8'h78;
  localparam logic [7:0] SC_OWN_DACK = 8'h80;
  localparam logic [7:0] SC_OWN_DNAK = 8'h88;
  localparam logic [7:0] SC_GC_DACK  = 8'h90;
  localparam logic [7:0] SC_GC_DNAK  = 8'h98;
  localparam logic [7:0] SC_END      = 8'hA0;
  localparam logic [7:0] SC_NONE     = 8'hF8;
endpackage

// File: rtl/i2cgc_filter.sv
module i2cgc_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic clean_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    win_q;
  logic                   clean_q;

  // the line only changes once FILT_LEN consecutive samples agree
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '1;
      win_q   <= '1;
      clean_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
      win_q  <= {win_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      if (&win_q)       clean_q <= 1'b1;
      else if (~|win_q) clean_q <= 1'b0;
    end
  end

  assign clean_o = clean_q;
endmodule

// File: rtl/i2cgc_events.sv
module i2cgc_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o,
  output logic busy_o
);
  logic scl_p, sda_p, busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
      busy_q <= 1'b0;
    end else begin
      scl_p <= scl_i;
      sda_p <= sda_i;
      if (start_o)     busy_q <= 1'b1;
      else if (stop_o) busy_q <= 1'b0;
    end
  end

  assign start_o = scl_i & scl_p & sda_p & ~sda_i;
  assign stop_o  = scl_i & scl_p & ~sda_p & sda_i;
  assign rise_o  = scl_i & ~scl_p;
  assign fall_o  = ~scl_i & scl_p;
  assign busy_o  = busy_q;
endmodule

// File: rtl/i2cgc_engine.sv
module i2cgc_engine
  import i2cgc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_f_i,
  input  logic       sda_f_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       rise_i,
  input  logic       fall_i,
  input  logic       aa_i,
  input  logic [6:0] own_addr_i,
  input  logic       gc_en_i,
  input  logic       arb_lost_i,
  input  logic       sto_i,
  output logic       evt_o,
  output logic [7:0] evt_code_o,
  output logic       evt_hold_o,
  output logic       ack_drv_o,
  output logic [7:0] rx_data_o,
  output logic       wake_o
);
  eng_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       shreg_q, rx_q, code_q;
  logic             gc_mode_q, nak_q, arb_q, ack_q, evt_q, hold_q, wake_q;
  logic             match_gc, match_own;

  assign match_gc  = gc_en_i && aa_i && (shreg_q == 8'h00);
  assign match_own = aa_i && (|own_addr_i) && (shreg_q[7:1] == own_addr_i) && !shreg_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;  cnt_q <= '0;  shreg_q <= '0;  rx_q <= '0;
      code_q <= SC_NONE;   gc_mode_q <= 1'b0;  nak_q <= 1'b0;  arb_q <= 1'b0;
      ack_q <= 1'b0;       evt_q <= 1'b0;  hold_q <= 1'b0;  wake_q <= 1'b0;
    end else begin
      evt_q  <= 1'b0;
      wake_q <= 1'b0;
      if (arb_lost_i) arb_q <= 1'b1;
      if (sto_i) begin
        state_q <= ST_IDLE;
        ack_q   <= 1'b0;
      end else if (start_i || stop_i) begin
        if (state_q == ST_DATA) begin
          evt_q  <= 1'b1;
          code_q <= SC_END;
          hold_q <= 1'b0;
        end
        ack_q   <= 1'b0;
        cnt_q   <= '0;
        state_q <= start_i ? ST_ADDR : ST_IDLE;
      end else begin
        case (state_q)
          ST_ADDR, ST_DATA: begin
            if (rise_i) begin
              shreg_q <= {shreg_q[6:0], sda_f_i};
              cnt_q   <= cnt_q + 1'b1;
            end else if (fall_i && cnt_q == CNT_W'(BYTE_BITS)) begin
              if (state_q == ST_ADDR) begin
                if (match_gc || match_own) begin
                  ack_q     <= 1'b1;
                  evt_q     <= 1'b1;
                  hold_q    <= 1'b1;
                  wake_q    <= 1'b1;
                  gc_mode_q <= match_gc;
                  nak_q     <= 1'b0;
                  arb_q     <= 1'b0;
                  code_q    <= match_gc ? (arb_q ? SC_GC_ARB : SC_GC_ACK)
                                        : (arb_q ? SC_OWN_ARB : SC_OWN_ACK);
                  state_q   <= ST_ACK;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else begin
                rx_q    <= shreg_q;
                ack_q   <= aa_i;
                nak_q   <= !aa_i;
                evt_q   <= 1'b1;
                hold_q  <= 1'b1;
                code_q  <= gc_mode_q ? (aa_i ? SC_GC_DACK : SC_GC_DNAK)
                                     : (aa_i ? SC_OWN_DACK : SC_OWN_DNAK);
                state_q <= ST_ACK;
              end
            end
          end
          ST_ACK: if (fall_i) begin
            ack_q   <= 1'b0;
            cnt_q   <= '0;
            state_q <= nak_q ? ST_IDLE : ST_DATA;
          end
          default: ;
        endcase
      end
    end
  end

  assign evt_o      = evt_q;
  assign evt_code_o = code_q;
  assign evt_hold_o = hold_q;
  assign ack_drv_o  = ack_q;
  assign rx_data_o  = rx_q;
  assign wake_o     = wake_q;

  // R2: the acknowledge is put on SDA only while SCL is low
  p_ack_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> !scl_f_i);
  // R9: a wake pulse always coincides with a driven acknowledge
  p_wake_with_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |-> ack_q);
endmodule

// File: rtl/i2cgc_slave_rx.sv
module i2cgc_slave_rx
  import i2cgc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe_o,
  output logic       sda_oe_o,
  input  logic       addr_we_i,
  input  logic [7:0] addr_wdata_i,
  input  logic       ctl_we_i,
  input  logic       ctl_sta_i,
  input  logic       ctl_sto_i,
  input  logic       ctl_si_i,
  input  logic       ctl_aa_i,
  input  logic       arb_lost_i,
  output logic [7:0] status_o,
  output logic       si_o,
  output logic [7:0] rx_data_o,
  output logic       wake_o,
  output logic       start_go_o
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw, clean;
  logic start_e, stop_e, rise_e, fall_e, busy;
  logic evt, evt_hold, ack_drv;
  logic [7:0] evt_code;
  logic [7:0] addr_q, code_q;
  logic aa_q, si_q, hold_q, sta_pend_q, go_q;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    i2cgc_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw_i(raw[g]), .clean_o(clean[g]));
  end

  i2cgc_events u_evt (
    .clk(clk), .rst_n(rst_n), .scl_i(clean[0]), .sda_i(clean[1]),
    .start_o(start_e), .stop_o(stop_e), .rise_o(rise_e), .fall_o(fall_e),
    .busy_o(busy));

  i2cgc_engine u_eng (
    .clk(clk), .rst_n(rst_n), .scl_f_i(clean[0]), .sda_f_i(clean[1]),
    .start_i(start_e), .stop_i(stop_e), .rise_i(rise_e), .fall_i(fall_e),
    .aa_i(aa_q), .own_addr_i(addr_q[7:1]), .gc_en_i(addr_q[0]),
    .arb_lost_i(arb_lost_i), .sto_i(ctl_we_i & ctl_sto_i),
    .evt_o(evt), .evt_code_o(evt_code), .evt_hold_o(evt_hold),
    .ack_drv_o(ack_drv), .rx_data_o(rx_data_o), .wake_o(wake_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= 8'h00;  code_q <= SC_NONE;  aa_q <= 1'b0;  si_q <= 1'b0;
      hold_q <= 1'b0;   sta_pend_q <= 1'b0; go_q <= 1'b0;
    end else begin
      if (addr_we_i) addr_q <= addr_wdata_i;
      go_q <= 1'b0;
      if (sta_pend_q && !busy) begin
        go_q       <= 1'b1;
        sta_pend_q <= 1'b0;
      end
      if (ctl_we_i) begin
        aa_q <= ctl_aa_i;
        if (ctl_si_i)  si_q <= 1'b0;
        if (ctl_sta_i) sta_pend_q <= 1'b1;
      end
      if (evt) begin
        si_q   <= 1'b1;
        code_q <= evt_code;
        hold_q <= evt_hold;
      end
    end
  end

  assign status_o   = si_q ? code_q : SC_NONE;
  assign si_o       = si_q;
  assign scl_oe_o   = si_q & hold_q;
  assign sda_oe_o   = ack_drv;
  assign start_go_o = go_q;

  // R2: a general-call status implies the enable bit is set
  p_gc_needs_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (si_q && (code_q == SC_GC_ACK || code_q == SC_GC_ARB)) |-> addr_q[0]);
  // R3: an own-address status implies a nonzero own address
  p_own_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (si_q && (code_q == SC_OWN_ACK || code_q == SC_OWN_ARB)) |-> (addr_q[7:1] != 7'd0));
  // R5: a refused byte leaves SDA released
  p_nak_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (si_q && (code_q == SC_GC_DNAK || code_q == SC_OWN_DNAK)) |-> !sda_oe_o);
  // R6: an end-of-transfer status never holds SCL
  p_end_no_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (si_q && code_q == SC_END) |-> !scl_oe_o);
  // R8: the START request is a single-cycle pulse
  p_go_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    go_q |=> !go_q);
endmodule

// File: tb/test_i2cgc_slave_rx.sv
module test_i2cgc_slave_rx;
  localparam int Q = 16;

  typedef struct packed {
    logic [7:0] code;
    logic [7:0] data;
    logic       aa;
    logic       sta;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_oe, sda_oe, scl_line, sda_line;
  logic addr_we = 1'b0, ctl_we = 1'b0, ctl_sta = 1'b0, ctl_sto = 1'b0;
  logic ctl_si = 1'b0, ctl_aa = 1'b0, arb_lost = 1'b0;
  logic [7:0] addr_wdata = 8'h00;
  logic [7:0] status, rx_data;
  logic si, wake, start_go;
  int checks = 0, failures = 0, wake_cnt = 0, go_cnt = 0;
  item_t exp_q[$];

  always #10 clk = ~clk;

  assign scl_line = scl_m & ~scl_oe;
  assign sda_line = sda_m & ~sda_oe;

  i2cgc_slave_rx i_i2cgc_slave_rx (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .addr_we_i(addr_we),
    .addr_wdata_i(addr_wdata), .ctl_we_i(ctl_we), .ctl_sta_i(ctl_sta),
    .ctl_sto_i(ctl_sto), .ctl_si_i(ctl_si), .ctl_aa_i(ctl_aa),
    .arb_lost_i(arb_lost), .status_o(status), .si_o(si), .rx_data_o(rx_data),
    .wake_o(wake), .start_go_o(start_go));

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (wake) wake_cnt++;
    if (start_go) go_cnt++;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl_high();
    while (!scl_line) @(negedge clk);
  endtask

  task automatic mbit(input logic b, input bit glitch);
    sda_m = b; cyc(Q);
    scl_m = 1'b1; wait_scl_high(); cyc(Q);
    if (glitch) begin sda_m = 1'b1; cyc(1); sda_m = b; end
    cyc(Q);
    scl_m = 1'b0; cyc(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack,
                           input int glitch_bit, input string tag);
    logic got;
    for (int i = 7; i >= 0; i--) mbit(b[i], i == glitch_bit);
    sda_m = 1'b1; cyc(Q);
    scl_m = 1'b1; wait_scl_high(); cyc(Q);
    got = sda_line; cyc(Q);
    scl_m = 1'b0; cyc(Q);
    chk(got == !exp_ack, tag, "acknowledge (SDA level in 9th clock)", got, !exp_ack);
  endtask

  task automatic m_start();
    sda_m = 1'b1; cyc(Q);
    scl_m = 1'b1; wait_scl_high(); cyc(Q);
    sda_m = 1'b0; cyc(Q);
    scl_m = 1'b0; cyc(Q);
  endtask

  task automatic m_stop();
    sda_m = 1'b0; cyc(Q);
    scl_m = 1'b1; wait_scl_high(); cyc(Q);
    sda_m = 1'b1; cyc(2 * Q);
  endtask

  task automatic expect_evt(input logic [7:0] code, input logic [7:0] data,
                            input logic aa, input logic sta);
    item_t it;
    it.code = code; it.data = data; it.aa = aa; it.sta = sta;
    exp_q.push_back(it);
  endtask

  task automatic set_addr(input logic [7:0] v);
    @(negedge clk); addr_wdata = v; addr_we = 1'b1;
    @(negedge clk); addr_we = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || si) @(negedge clk);
    cyc(4);
  endtask

  // scoreboard monitor, also plays the software side
  initial begin
    item_t it;
    bit known;
    wait (rst_n);
    cyc(2);
    ctl_we = 1'b1; ctl_aa = 1'b1; cyc(1); ctl_we = 1'b0;
    forever begin
      @(negedge clk);
      if (si) begin
        known = (exp_q.size() != 0);
        if (known) begin
          it = exp_q.pop_front();
          chk(status == it.code, "R2 R3 R4 R5 R6", "status code", status, it.code);
          if (it.code inside {8'h80, 8'h88, 8'h90, 8'h98})
            chk(rx_data == it.data, "R5", "received byte", rx_data, it.data);
          chk(scl_oe == (it.code != 8'hA0), "R10", "SCL hold while SI",
              scl_oe, it.code != 8'hA0);
        end else begin
          it = '0; it.aa = 1'b1;
          chk(1'b0, "R7", "unexpected SI, status", status, 8'hF8);
        end
        ctl_we = 1'b1; ctl_si = 1'b1; ctl_aa = it.aa; ctl_sta = it.sta;
        @(negedge clk);
        ctl_we = 1'b0; ctl_si = 1'b0; ctl_sta = 1'b0;
        chk(!si && status == 8'hF8 && !scl_oe, "R10", "after SI clear: status",
            status, 8'hF8);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int w0, g0;
    cyc(5);
    chk(status == 8'hF8 && !si, "R1", "reset status", status, 8'hF8);
    chk(!scl_oe && !sda_oe, "R1", "reset line drive", {scl_oe, sda_oe}, 0);
    rst_n = 1'b1;
    cyc(10);

    // R1/R2/R3: register 0x00 -> neither GC nor own address 0 responds
    m_start(); send_byte(8'h00, 1'b0, -1, "R1 R3"); m_stop();
    chk(wake_cnt == 0, "R9", "wake after rejected address", wake_cnt, 0);

    // GC with glitch on a data bit, then NAK and ignored byte
    set_addr(8'h55);
    expect_evt(8'h70, 8'h00, 1'b1, 1'b0);
    m_start(); send_byte(8'h00, 1'b1, -1, "R2");
    expect_evt(8'h90, 8'hA5, 1'b0, 1'b0);
    send_byte(8'hA5, 1'b1, 6, "R11");
    expect_evt(8'h98, 8'h3C, 1'b1, 1'b0);
    send_byte(8'h3C, 1'b0, -1, "R5");
    send_byte(8'h11, 1'b0, -1, "R7");
    m_stop(); drain();
    chk(wake_cnt == 1, "R9", "wake count after GC", wake_cnt, 1);
    chk(go_cnt == 0, "R8", "no START without request", go_cnt, 0);

    // GC ending in STOP with STA request
    expect_evt(8'h70, 8'h00, 1'b1, 1'b0);
    m_start(); send_byte(8'h00, 1'b1, -1, "R2");
    expect_evt(8'h90, 8'h5A, 1'b1, 1'b0);
    send_byte(8'h5A, 1'b1, -1, "R5");
    expect_evt(8'hA0, 8'h00, 1'b1, 1'b1);
    m_stop(); drain();
    chk(go_cnt == 1, "R8", "START pulse after STOP", go_cnt, 1);

    // own address, repeated START into GC
    w0 = wake_cnt;
    expect_evt(8'h60, 8'h00, 1'b1, 1'b0);
    m_start(); send_byte(8'h54, 1'b1, -1, "R3");
    expect_evt(8'h80, 8'h81, 1'b1, 1'b0);
    send_byte(8'h81, 1'b1, -1, "R5");
    expect_evt(8'hA0, 8'h00, 1'b1, 1'b0);
    expect_evt(8'h70, 8'h00, 1'b1, 1'b0);
    m_start(); send_byte(8'h00, 1'b1, -1, "R6");
    expect_evt(8'h90, 8'hC3, 1'b1, 1'b0);
    send_byte(8'hC3, 1'b1, -1, "R5");
    expect_evt(8'hA0, 8'h00, 1'b1, 1'b0);
    m_stop(); drain();
    chk(wake_cnt == w0 + 2, "R9", "wake count own+GC", wake_cnt, w0 + 2);

    // lost arbitration variants
    @(negedge clk); arb_lost = 1'b1; @(negedge clk); arb_lost = 1'b0;
    expect_evt(8'h78, 8'h00, 1'b1, 1'b0);
    m_start(); send_byte(8'h00, 1'b1, -1, "R4");
    expect_evt(8'hA0, 8'h00, 1'b1, 1'b0);
    m_stop(); drain();
    @(negedge clk); arb_lost = 1'b1; @(negedge clk); arb_lost = 1'b0;
    expect_evt(8'h68, 8'h00, 1'b1, 1'b0);
    m_start(); send_byte(8'h54, 1'b1, -1, "R4");
    expect_evt(8'hA0, 8'h00, 1'b1, 1'b0);
    m_stop(); drain();

    // NAK with STA: START waits for bus free
    g0 = go_cnt;
    expect_evt(8'h70, 8'h00, 1'b0, 1'b0);
    m_start(); send_byte(8'h00, 1'b1, -1, "R2");
    expect_evt(8'h98, 8'h77, 1'b1, 1'b1);
    send_byte(8'h77, 1'b0, -1, "R5");
    drain();
    chk(go_cnt == g0, "R8", "no START while bus busy", go_cnt, g0);
    m_stop(); cyc(10);
    chk(go_cnt == g0 + 1, "R8", "START after bus free", go_cnt, g0 + 1);

    // GC disabled
    set_addr(8'h54);
    w0 = wake_cnt;
    m_start(); send_byte(8'h00, 1'b0, -1, "R2"); m_stop(); drain();
    chk(wake_cnt == w0, "R9", "no wake on disabled GC", wake_cnt, w0);

    // AA=0 after 0xA0: nothing recognised
    set_addr(8'h55);
    expect_evt(8'h60, 8'h00, 1'b1, 1'b0);
    m_start(); send_byte(8'h54, 1'b1, -1, "R3");
    expect_evt(8'hA0, 8'h00, 1'b0, 1'b0);
    m_stop(); drain();
    m_start(); send_byte(8'h54, 1'b0, -1, "R7"); m_stop();
    m_start(); send_byte(8'h00, 1'b0, -1, "R7"); m_stop();
    drain();

    chk(exp_q.size() == 0, "R10", "unconsumed expected statuses", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule